// File: doc/BRIEF.md
# Audio Record and Playback Controller

This block captures a stream of stereo audio words into an external sample memory and later streams them back out. Two key inputs control it. Each key input is a single-cycle pulse that has already been debounced. One key toggles recording and the other toggles playback. Incoming samples arrive as a word qualified by a valid strobe. Outgoing samples are offered on a valid/ready handshake. Each stereo word carries both channels, so its width is a parameter.

The memory is reached through a synchronous request/ready port. The block holds a request, with its address, write enable and write data, until the memory returns ready. For a read, the data is taken in the same cycle that ready is high. Every recording starts at address zero. When a recording ends, the block latches the number of samples committed to memory, and that count bounds the next playback. A recording also stops by itself when the memory is full. Two status lights and an active-high seven-segment code show the current mode.

Top module: `audio_recplay`

## Requirements
- R1: In idle, a record-key pulse starts recording. From the cycle after the pulse, the record light is on. Accepted samples are written to consecutive addresses starting at zero, and the write data equals the sample word.
- R2: While recording, a second record-key pulse ends recording, and the record light is off from the next cycle. A write that the memory has not yet accepted is discarded and does not count toward the recorded length.
- R3: When all 2^ADDR_W locations have been written, recording ends without a key press. The record light goes off, and further input samples are not stored.
- R4: In idle, a play-key pulse starts playback when the recorded length is non-zero, and the play light is on while playback runs. Samples are read from address zero upward and offered in order on the output handshake. When the recorded length is zero, the play key is ignored.
- R5: Playback ends, and the play light goes off, on a second play-key pulse or after the last recorded sample has been accepted at the output. Exactly as many samples are delivered as were committed during recording.
- R6: The segment output uses bit 0 for segment a through bit 6 for segment g, with segments active-high. It reads 7'h00 in idle, 7'h50 (the letter r) while recording, and 7'h73 (the letter P) while playing.
- R7: Only one mode is active at a time. While recording, the play key is ignored. While playing, the record key is ignored.
- R8: A sample that arrives while a write is pending and not accepted in that cycle is dropped, and it sets a sticky overflow flag. The flag clears when a new recording starts.
- R9: A memory request keeps its address, write enable and write data stable until ready, unless its mode ends. An offered output sample stays stable until it is accepted.
- R10: After reset, the block is idle with both lights off, a blank segment code, no memory request, no output valid and the overflow flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_rec | input | 1 | Record toggle pulse |
| key_play | input | 1 | Play toggle pulse |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | SAMPLE_W | Stereo input word |
| out_valid | output | 1 | Output sample offered |
| out_ready | input | 1 | Output sample taken |
| out_sample | output | SAMPLE_W | Stereo output word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | SAMPLE_W | Write data |
| mem_ready | input | 1 | Memory accepts request; read data valid |
| mem_rdata | input | SAMPLE_W | Read data |
| led_rec | output | 1 | Recording light |
| led_play | output | 1 | Playback light |
| seg | output | 7 | Segment code, bit 0 = a |
| overflow | output | 1 | Sticky dropped-sample flag |

## Verification
A corrupted write pointer shows up as samples stored at the wrong memory words. It also makes playback return them out of order, which is visible within one record/play round. A wrong latched length shows up in a single playback: the play light falls early or late, and the delivered sample count is off. A mode register that drifts or admits the wrong key becomes visible the cycle after the key pulse, as a wrong light or segment pattern. The same fault also appears as a memory request of the wrong direction.

// File: rtl/audrec_pkg.sv
package audrec_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_REC  = 2'd1,
        MODE_PLAY = 2'd2
    } mode_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_OFFER = 1'b1
    } rd_phase_e;

    // Segment bit 0 = a ... bit 6 = g, active high
    localparam logic [6:0] SEG_BLANK = 7'h00;
    localparam logic [6:0] SEG_R     = 7'h50;  // e, g
    localparam logic [6:0] SEG_P     = 7'h73;  // a, b, e, f, g

    function automatic logic [6:0] seg_code(input mode_e m);
        case (m)
            MODE_REC:  return SEG_R;
            MODE_PLAY: return SEG_P;
            default:   return SEG_BLANK;
        endcase
    endfunction

endpackage

// File: rtl/audrec_mode_ctl.sv
module audrec_mode_ctl
    import audrec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  key_rec,
    input  logic  key_play,
    input  logic  full,
    input  logic  done,
    input  logic  has_data,
    output mode_e mode,
    output logic  rec_start,
    output logic  rec_stop
);

    mode_e mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        case (mode_q)
            MODE_IDLE: begin
                if (key_rec)
                    mode_d = MODE_REC;
                else if (key_play && has_data)
                    mode_d = MODE_PLAY;
            end
            MODE_REC:  if (key_rec || full) mode_d = MODE_IDLE;
            MODE_PLAY: if (key_play || done) mode_d = MODE_IDLE;
            default:   mode_d = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_IDLE;
        else     mode_q <= mode_d;
    end

    assign mode      = mode_q;
    assign rec_start = (mode_q == MODE_IDLE) && (mode_d == MODE_REC);
    assign rec_stop  = (mode_q == MODE_REC)  && (mode_d == MODE_IDLE);

endmodule

// File: rtl/audrec_rec_path.sv
module audrec_rec_path #(
    parameter int ADDR_W   = 10,
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                active,
    input  logic                rec_start,
    input  logic                rec_stop,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                mem_ready,
    output logic                wr_req,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [SAMPLE_W-1:0] wr_data,
    output logic                full,
    output logic [ADDR_W:0]     rec_len,
    output logic                overflow
);

    localparam int             DEPTH    = 1 << ADDR_W;
    localparam logic [ADDR_W:0] FULL_CNT = DEPTH[ADDR_W:0];

    logic [ADDR_W:0]   ptr_q, ptr_nx;
    logic              pend_q;
    logic [SAMPLE_W-1:0] data_q;
    logic              accept, load, ovf_set;
    logic [ADDR_W:0]   len_q;
    logic              ovf_q;

    assign accept  = pend_q && mem_ready;
    assign ptr_nx  = ptr_q + {{ADDR_W{1'b0}}, accept};
    assign load    = active && in_valid && (ptr_nx != FULL_CNT) && (!pend_q || accept);
    assign ovf_set = active && in_valid && pend_q && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            pend_q <= 1'b0;
            data_q <= '0;
            len_q  <= '0;
        end else if (rec_stop) begin
            len_q  <= ptr_nx;
            ptr_q  <= '0;
            pend_q <= 1'b0;
        end else if (!active) begin
            ptr_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            ptr_q <= ptr_nx;
            if (load) begin
                pend_q <= 1'b1;
                data_q <= in_sample;
            end else if (accept) begin
                pend_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || rec_start) ovf_q <= 1'b0;
        else if (ovf_set)     ovf_q <= 1'b1;
    end

    assign wr_req   = pend_q;
    assign wr_addr  = ptr_q[ADDR_W-1:0];
    assign wr_data  = data_q;
    assign full     = (ptr_q == FULL_CNT);
    assign rec_len  = len_q;
    assign overflow = ovf_q;

endmodule

// File: rtl/audrec_play_path.sv
module audrec_play_path
    import audrec_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                active,
    input  logic [ADDR_W:0]     rec_len,
    input  logic                mem_ready,
    input  logic [SAMPLE_W-1:0] mem_rdata,
    input  logic                out_ready,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                done
);

    rd_phase_e           ph_q;
    logic [ADDR_W:0]     ptr_q;
    logic [SAMPLE_W-1:0] buf_q;
    logic                take, last;

    assign take = active && (ph_q == PH_OFFER) && out_ready;
    assign last = (ptr_q + 1'b1) == rec_len;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            ph_q  <= PH_FETCH;
            ptr_q <= '0;
        end else if (ph_q == PH_FETCH) begin
            if (mem_ready) ph_q <= PH_OFFER;
        end else if (out_ready) begin
            ph_q  <= PH_FETCH;
            ptr_q <= ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            buf_q <= '0;
        else if (active && ph_q == PH_FETCH && mem_ready)
            buf_q <= mem_rdata;
    end

    assign rd_req     = active && (ph_q == PH_FETCH);
    assign rd_addr    = ptr_q[ADDR_W-1:0];
    assign out_valid  = active && (ph_q == PH_OFFER);
    assign out_sample = buf_q;
    assign done       = take && last;

endmodule

// File: rtl/audio_recplay.sv
module audio_recplay
    import audrec_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                key_rec,
    input  logic                key_play,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [SAMPLE_W-1:0] mem_wdata,
    input  logic                mem_ready,
    input  logic [SAMPLE_W-1:0] mem_rdata,
    output logic                led_rec,
    output logic                led_play,
    output logic [6:0]          seg,
    output logic                overflow
);

    mode_e               mode;
    logic                rec_start, rec_stop, full, done;
    logic [ADDR_W:0]     rec_len;
    logic                wr_req, rd_req;
    logic [ADDR_W-1:0]   wr_addr, rd_addr;
    logic [SAMPLE_W-1:0] wr_data;

    audrec_mode_ctl u_mode (
        .clk       (clk),
        .rst       (rst),
        .key_rec   (key_rec),
        .key_play  (key_play),
        .full      (full),
        .done      (done),
        .has_data  (rec_len != '0),
        .mode      (mode),
        .rec_start (rec_start),
        .rec_stop  (rec_stop)
    );

    audrec_rec_path #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_rec (
        .clk       (clk),
        .rst       (rst),
        .active    (mode == MODE_REC),
        .rec_start (rec_start),
        .rec_stop  (rec_stop),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .mem_ready (mem_ready),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .full      (full),
        .rec_len   (rec_len),
        .overflow  (overflow)
    );

    audrec_play_path #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_play (
        .clk        (clk),
        .rst        (rst),
        .active     (mode == MODE_PLAY),
        .rec_len    (rec_len),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .out_ready  (out_ready),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .done       (done)
    );

    assign mem_req   = wr_req | rd_req;
    assign mem_we    = wr_req;
    assign mem_addr  = (mode == MODE_PLAY) ? rd_addr : wr_addr;
    assign mem_wdata = wr_data;
    assign led_rec   = (mode == MODE_REC);
    assign led_play  = (mode == MODE_PLAY);
    assign seg       = seg_code(mode);

endmodule

// File: rtl/audio_recplay_chk.sv
module audio_recplay_chk #(
    parameter int ADDR_W   = 10,
    parameter int SAMPLE_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                led_rec,
    input logic                led_play,
    input logic [6:0]          seg,
    input logic                mem_req,
    input logic                mem_we,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [SAMPLE_W-1:0] mem_wdata,
    input logic                mem_ready,
    input logic                in_valid,
    input logic                overflow,
    input logic                out_valid,
    input logic                out_ready,
    input logic [SAMPLE_W-1:0] out_sample
);

    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(led_rec && led_play));

    a_r2_write_in_rec: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> led_rec);

    a_r4_read_in_play: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> led_play);

    a_r6_seg_rec: assert property (@(posedge clk) disable iff (rst)
        led_rec |-> (seg == 7'h50));

    a_r6_seg_play: assert property (@(posedge clk) disable iff (rst)
        led_play |-> (seg == 7'h73));

    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready && (led_rec || led_play)) |=>
            (!(led_rec || led_play) ||
             (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))));

    a_r9_offer_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (!led_play || (out_valid && $stable(out_sample))));

    a_r5_offer_in_play: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> led_play);

    a_r8_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> ($past(in_valid) && $past(led_rec)));

endmodule

bind audio_recplay audio_recplay_chk #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .led_rec    (led_rec),
    .led_play   (led_play),
    .seg        (seg),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .in_valid   (in_valid),
    .overflow   (overflow),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample)
);

// File: tb/audio_recplay_bench.sv
module audio_recplay_bench;

    localparam int AW    = 3;
    localparam int SW    = 32;
    localparam int DEPTH = 1 << AW;
    localparam int NVEC  = 6;
    localparam logic [SW-1:0] VEC [NVEC] = '{
        32'h1234_5678, 32'hFFFF_0000, 32'h0000_FFFF,
        32'hA5A5_5A5A, 32'h0000_0001, 32'h8000_7FFF
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          key_rec = 1'b0, key_play = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_sample = '0;
    logic          out_valid, out_ready = 1'b0;
    logic [SW-1:0] out_sample;
    logic          mem_req, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [SW-1:0] mem_wdata, mem_rdata;
    logic          led_rec, led_play, overflow;
    logic [6:0]    seg;

    logic          stall = 1'b0;
    logic [SW-1:0] mem [DEPTH];
    logic [SW-1:0] got [16];
    int            n_got;
    int            n_chk = 0, n_fail = 0;
    bit            finished = 1'b0;

    always #5 clk = ~clk;

    audio_recplay #(.ADDR_W(AW), .SAMPLE_W(SW)) u_audio_recplay (
        .clk(clk), .rst(rst), .key_rec(key_rec), .key_play(key_play),
        .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .led_rec(led_rec), .led_play(led_play), .seg(seg), .overflow(overflow)
    );

    // memory model: ready one cycle after a request, data with ready
    always @(posedge clk) begin
        if (rst) begin
            mem_ready <= 1'b0;
        end else begin
            mem_ready <= mem_req && !mem_ready && !stall;
            mem_rdata <= mem[mem_addr];
            if (mem_req && mem_ready && mem_we) mem[mem_addr] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [SW-1:0] act,
                       input logic [SW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press_rec;
        key_rec = 1'b1; @(negedge clk); key_rec = 1'b0;
    endtask

    task automatic press_play;
        key_play = 1'b1; @(negedge clk); key_play = 1'b0;
    endtask

    task automatic send(input logic [SW-1:0] s);
        in_valid = 1'b1; in_sample = s; @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic collect;
        n_got = 0;
        out_ready = 1'b1;
        for (int c = 0; c < 200; c++) begin
            if (!led_play) break;
            if (out_valid && n_got < 16) begin
                got[n_got] = out_sample;
                n_got++;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        // R10 reset state
        chk(!led_rec && !led_play && !mem_req && !out_valid && !overflow, "R10 idle",
            {led_rec, led_play, mem_req, out_valid, overflow}, 0);
        chk(seg == 7'h00, "R6 blank", seg, 7'h00);

        // R4 play with nothing recorded is ignored
        press_play; wait_n(1);
        chk(!led_play, "R4 empty play ignored", led_play, 0);

        // R1 record the vector table
        press_rec;
        chk(led_rec, "R1 rec light", led_rec, 1);
        chk(seg == 7'h50, "R6 seg r", seg, 7'h50);
        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i]);
            wait_n(4);
            chk(mem[i] == VEC[i], "R1 stored word", mem[i], VEC[i]);
        end
        // R7 play key ignored while recording
        press_play;
        chk(led_rec && !led_play, "R7 play ignored in rec", {led_rec, led_play}, 2'b10);
        // R2 stop
        press_rec;
        chk(!led_rec, "R2 rec light off", led_rec, 0);
        chk(seg == 7'h00, "R6 blank after rec", seg, 0);

        // R4 start play, hold output
        press_play;
        chk(led_play && seg == 7'h73, "R6 seg P", seg, 7'h73);
        wait_n(5);
        chk(out_valid && out_sample == VEC[0], "R4 first sample", out_sample, VEC[0]);
        press_rec;
        chk(!led_rec && led_play, "R7 rec ignored in play", {led_rec, led_play}, 2'b01);
        chk(out_sample == VEC[0], "R9 offer held", out_sample, VEC[0]);
        press_play;
        chk(!led_play && !out_valid, "R5 stop by key", {led_play, out_valid}, 0);

        // R5 full playback bounded by length
        press_play;
        collect;
        chk(n_got == NVEC, "R5 sample count", n_got, NVEC);
        for (int i = 0; i < NVEC; i++)
            chk(got[i] == VEC[i], "R4 playback order", got[i], VEC[i]);
        chk(!led_play, "R5 light off at end", led_play, 0);

        // R8 overflow while a write is pending
        stall = 1'b1;
        press_rec;
        send(32'hDEAD_0001);
        send(32'hDEAD_0002);
        wait_n(1);
        chk(overflow, "R8 overflow set", overflow, 1);
        stall = 1'b0;
        wait_n(4);
        press_rec;
        chk(overflow, "R8 overflow sticky", overflow, 1);
        press_play;
        collect;
        chk(n_got == 1 && got[0] == 32'hDEAD_0001, "R8 dropped sample", got[0], 32'hDEAD_0001);
        chk(n_got == 1, "R8 length one", n_got, 1);

        // R8 clear on start; R2 pending write discarded
        stall = 1'b1;
        press_rec;
        chk(!overflow, "R8 cleared at start", overflow, 0);
        send(32'hBEEF_0000);
        wait_n(2);
        press_rec;
        stall = 1'b0;
        wait_n(3);
        press_play; wait_n(1);
        chk(!led_play, "R2 pending write dropped, play ignored", led_play, 0);

        // R3 auto stop when full
        press_rec;
        for (int i = 0; i < DEPTH + 2; i++) begin
            send(32'h100 + i);
            wait_n(4);
        end
        chk(!led_rec, "R3 auto stop", led_rec, 0);
        press_play;
        collect;
        chk(n_got == DEPTH, "R3 full length", n_got, DEPTH);
        for (int i = 0; i < DEPTH; i++)
            chk(got[i] == 32'h100 + i, "R3 full contents", got[i], 32'h100 + i);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule